// File: doc/BRIEF.md
# Replay FIFO with Half-Full Flag

A single-clock first-in first-out buffer for 9-bit words whose depth is a parameter between 512 and 8192 entries. Writes and reads are requested with active-low strobes that are sampled on the rising clock edge. A write is taken only if the buffer has room. A read is taken only if the buffer holds data, and the word read appears on the output in the next cycle. Active-low status outputs report empty, full and more-than-half-full.

A rewind input supports write-once, read-many traffic. While it is held low, the read position returns to the first location and the write position stays where it is, so the stored words can be read out again from the start. All status outputs then follow the occupancy reloaded from the write position. The read port has an output-enable that stands in for a tri-stated bus. It is high only in the cycle that presents a word taken by an accepted read.

Top module: `replay_fifo`

## Requirements
- R1: Words are 9 bits wide and leave in the order they entered. The depth parameter `DEPTH` is a power of two from 512 to 8192.
- R2: On any rising edge with `rst_n` low, both positions go to location zero and the output register clears to 0. After that edge, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0.
- R3: A write strobe (`wr_n`=0) stores `din` only when `full_n` is 1. A write strobe seen while full stores nothing, and the words read afterwards show it.
- R4: From reset, with no reads, `full_n` is still 1 after `DEPTH`-1 writes and goes to 0 in the cycle after write number `DEPTH`.
- R5: A read strobe (`rd_n`=0) while `empty_n` is 0 is ignored: `dout_oe` stays 0 and the occupancy does not change.
- R6: `empty_n` goes to 0 in the cycle after the last stored word is read.
- R7: `half_n` goes to 0 after the write that brings the occupancy above `DEPTH`/2. It returns to 1 after the read that brings the occupancy to `DEPTH`/2 or less.
- R8: A clock edge with `rt_n`=0 sets the read position to location zero and leaves the write position unchanged. The occupancy becomes the number of words written since reset (which must not exceed `DEPTH`), and all flags follow it in the next cycle.
- R9: Read and write strobes are ignored on any edge where `rt_n` or `rst_n` is 0.
- R10: `dout_oe` is 1 in the cycle after an accepted read, and `dout` then carries that word. In every other cycle `dout_oe` is 0.
- R11: When a read and a write are requested together, the occupancy stays unchanged if the buffer is neither empty nor full. If it is empty, only the write takes effect. If it is full, only the read takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind read position to zero, active low |
| din | input | 9 | Word to store |
| dout | output | 9 | Word taken by the last accepted read |
| dout_oe | output | 1 | High while `dout` drives a freshly read word |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when `DEPTH` words are stored |
| half_n | output | 1 | Low when more than `DEPTH`/2 words are stored |

## Verification
A write and a read can be accepted on the same edge, and the outcome depends on the occupancy at that edge. The bench requests both strobes together in three states: right after reset with the buffer empty, with the buffer partly filled, and after a complete fill. It compares the flags, `dout_oe` and the replayed data with a queue model, which lets only the write through when empty and only the read through when full. The rewind is also presented together with both strobes held active. The bench checks that the strobes are dropped and that the occupancy reloads to the count of words written.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;

  // occupancy after one edge, given which transfers were accepted
  function automatic int unsigned occ_step(int unsigned occ, logic took_wr, logic took_rd);
    return occ + int'(took_wr) - int'(took_rd);
  endfunction

  // occupancy reloaded on rewind: words written since reset, capped at depth
  function automatic int unsigned occ_rewind(int unsigned written, int unsigned depth);
    return (written > depth) ? depth : written;
  endfunction

  function automatic logic above_half(int unsigned occ, int unsigned depth);
    return occ > (depth / 2);
  endfunction
endpackage

// File: rtl/replay_fifo_ptrs.sv
module replay_fifo_ptrs #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rt_n,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] occ
);
  import replay_fifo_pkg::*;

  localparam logic [CW-1:0] FULL_OCC = CW'(DEPTH);

  logic [CW-1:0] wr_tot_q;
  logic [AW-1:0] rd_ptr_q;
  logic [CW-1:0] occ_q;
  logic [CW-1:0] occ_d;
  logic [CW-1:0] occ_rw;
  logic          wr_req;
  logic          rd_req;

  // strobes count only while the rewind is idle
  assign wr_req = !wr_n && rt_n;
  assign rd_req = !rd_n && rt_n;
  assign wr_acc = wr_req && (occ_q != FULL_OCC);
  assign rd_acc = rd_req && (occ_q != '0);

  assign occ_d  = CW'(occ_step(int'(occ_q), wr_acc, rd_acc));
  assign occ_rw = CW'(occ_rewind(int'(wr_tot_q), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_tot_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else if (!rt_n) begin
      rd_ptr_q <= '0;
      occ_q    <= occ_rw;
    end else begin
      if (wr_acc) wr_tot_q <= wr_tot_q + 1'b1;
      if (rd_acc) rd_ptr_q <= rd_ptr_q + 1'b1;
      occ_q <= occ_d;
    end
  end

  assign wr_addr = wr_tot_q[AW-1:0];
  assign rd_addr = rd_ptr_q;
  assign occ     = occ_q;

  a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && rt_n && occ_q == FULL_OCC) |=> $stable(wr_tot_q));

  a_r5_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && rt_n && occ_q == '0) |=> ($stable(rd_ptr_q) && occ_q != '1));

  a_r8_rewind_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rd_ptr_q == '0 && $stable(wr_tot_q)));

  a_r11_both_keeps_occ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_acc) |=> $stable(occ_q));

  a_r4_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= FULL_OCC);
endmodule

// File: rtl/replay_fifo_flags.sv
module replay_fifo_flags #(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] occ,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  import replay_fifo_pkg::*;

  always_comb begin
    empty_n = (occ != '0);
    full_n  = (occ != CW'(DEPTH));
    half_n  = !above_half(int'(occ), DEPTH);
  end
endmodule

// File: rtl/replay_fifo_store.sv
module replay_fifo_store #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  replay_fifo_pkg::word_t wr_data,
  input  logic                   rd_en,
  input  logic [AW-1:0]          rd_addr,
  output replay_fifo_pkg::word_t rd_data,
  output logic                   rd_vld
);
  import replay_fifo_pkg::*;

  word_t mem [DEPTH];
  word_t rd_q;
  logic  vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) rd_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_q;
  assign rd_vld  = vld_q;

  a_r10_vld_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(rd_en));
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
  parameter int DEPTH = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       rt_n,
  input  logic [8:0] din,
  output logic [8:0] dout,
  output logic       dout_oe,
  output logic       empty_n,
  output logic       full_n,
  output logic       half_n
);
  import replay_fifo_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] HALF_OCC = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL_OCC = CW'(DEPTH);

  generate
    if (DEPTH < 512 || DEPTH > 8192 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("replay_fifo: DEPTH must be a power of two in 512..8192");
    end
  endgenerate

  logic          wr_acc;
  logic          rd_acc;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] occ;

  replay_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .rt_n    (rt_n),
    .wr_acc  (wr_acc),
    .rd_acc  (rd_acc),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .occ     (occ)
  );

  replay_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .occ     (occ),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
  );

  replay_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_acc),
    .wr_addr (wr_addr),
    .wr_data (din),
    .rd_en   (rd_acc),
    .rd_addr (rd_addr),
    .rd_data (dout),
    .rd_vld  (dout_oe)
  );

  a_r2_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!empty_n && full_n && half_n && !dout_oe && dout == '0));

  a_r4_full_on_last_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !rd_acc && occ == FULL_OCC - 1'b1) |=> !full_n);

  a_r6_empty_on_last_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !wr_acc && occ == CW'(1)) |=> !empty_n);

  a_r7_half_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !rd_acc && occ == HALF_OCC) |=> !half_n);

  a_r7_half_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !wr_acc && occ == HALF_OCC + 1'b1) |=> half_n);

  a_r9_rewind_blocks_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> !dout_oe);
endmodule

// File: tb/replay_fifo_bench.sv
module replay_fifo_bench;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       dout_oe, empty_n, full_n, half_n;

  replay_fifo #(.DEPTH(DEPTH)) u_replay_fifo (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  int n_run = 0;
  int n_fail = 0;
  int hist[$];
  int rd_idx = 0;
  logic       exp_oe = 1'b0;
  logic [8:0] exp_dout = '0;

  function automatic int occ();
    return hist.size() - rd_idx;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk(empty_n == (occ() != 0), "R6 empty_n", empty_n, occ() != 0);
    chk(full_n == (occ() != DEPTH), "R4 full_n", full_n, occ() != DEPTH);
    chk(half_n == !(occ() > DEPTH / 2), "R7 half_n", half_n, !(occ() > DEPTH / 2));
    chk(dout_oe == exp_oe, "R10 dout_oe", dout_oe, exp_oe);
    if (exp_oe) chk(dout == exp_dout, "R1 dout order", dout, exp_dout);
  endtask

  // one clock: drive at falling edge, update model, check after rising edge
  task automatic step(input bit w, input bit r, input bit rt, input logic [8:0] d);
    bit racc, wacc;
    @(negedge clk);
    wr_n = !w; rd_n = !r; rt_n = !rt; din = d;
    if (rt) begin
      rd_idx = 0;
      exp_oe = 1'b0;
    end else begin
      racc = r && occ() > 0;
      wacc = w && occ() < DEPTH;
      exp_oe = racc;
      if (racc) begin
        exp_dout = 9'(hist[rd_idx]);
        rd_idx++;
      end
      if (wacc) hist.push_back(int'(d));
    end
    @(posedge clk); #1;
    check_all();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; rt_n = 1'b1; din = 9'h1FF;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(empty_n == 1'b0, "R2 empty_n in reset", empty_n, 0);
    chk(full_n == 1'b1, "R2 full_n in reset", full_n, 1);
    chk(half_n == 1'b1, "R2 half_n in reset", half_n, 1);
    chk(dout_oe == 1'b0, "R9 dout_oe in reset", dout_oe, 0);
    chk(dout == 9'h000, "R2 dout cleared", dout, 0);
    @(negedge clk);
    rst_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    hist.delete(); rd_idx = 0; exp_oe = 1'b0; exp_dout = '0;
  endtask

  task automatic t_order();
    t_reset();
    for (int i = 0; i < 6; i++) step(1, 0, 0, 9'(9'h0A5 + i * 37));
    for (int i = 0; i < 6; i++) step(0, 1, 0, '0);
    chk(empty_n == 1'b0, "R6 empty after last read", empty_n, 0);
    step(0, 1, 0, '0);
    chk(dout_oe == 1'b0, "R5 read while empty ignored", dout_oe, 0);
    step(1, 0, 0, 9'h123);
    step(0, 1, 0, '0);
    chk(dout == 9'h123, "R5 no skipped word after empty read", dout, 9'h123);
  endtask

  task automatic t_full();
    t_reset();
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 9'(i ^ 9'h15A));
    chk(full_n == 1'b1, "R4 not full at DEPTH-1", full_n, 1);
    step(1, 0, 0, 9'h0F0);
    chk(full_n == 1'b0, "R4 full at DEPTH", full_n, 0);
    step(1, 0, 0, 9'h1EE);
    chk(full_n == 1'b0, "R3 write while full dropped", full_n, 0);
    step(1, 1, 0, 9'h1DD);
    chk(full_n == 1'b1, "R11 full: only read taken", full_n, 1);
    chk(dout == 9'(0 ^ 9'h15A), "R11 full: read word", dout, 9'h15A);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 1, 0, '0);
    chk(empty_n == 1'b0, "R3 drained after dropped write", empty_n, 0);
  endtask

  task automatic t_half();
    t_reset();
    for (int i = 0; i < DEPTH / 2; i++) step(1, 0, 0, 9'(i));
    chk(half_n == 1'b1, "R7 exactly half not flagged", half_n, 1);
    step(1, 0, 0, 9'h1AA);
    chk(half_n == 1'b0, "R7 above half flagged", half_n, 0);
    step(1, 1, 0, 9'h1BB);
    chk(half_n == 1'b0, "R7 held through read+write", half_n, 0);
    step(0, 1, 0, '0);
    chk(half_n == 1'b1, "R7 cleared at half", half_n, 1);
  endtask

  task automatic t_both();
    t_reset();
    step(1, 1, 0, 9'h055);
    chk(empty_n == 1'b1, "R11 empty: write taken", empty_n, 1);
    chk(dout_oe == 1'b0, "R11 empty: read dropped", dout_oe, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 9'(9'h100 + i));
    for (int i = 0; i < 8; i++) step(1, 1, 0, 9'(9'h080 + i));
    chk(occ() == 5, "R11 mid: occupancy unchanged", occ(), 5);
    for (int i = 0; i < 5; i++) step(0, 1, 0, '0);
  endtask

  task automatic t_retx();
    t_reset();
    for (int i = 0; i < 10; i++) step(1, 0, 0, 9'(9'h033 * (i + 1)));
    for (int i = 0; i < 4; i++) step(0, 1, 0, '0);
    step(1, 1, 1, 9'h1FF);
    chk(dout_oe == 1'b0, "R9 strobes ignored during rewind", dout_oe, 0);
    chk(empty_n == 1'b1, "R8 flags after rewind", empty_n, 1);
    step(0, 1, 0, '0);
    chk(dout == 9'h033, "R8 replay from location zero", dout, 9'h033);
    for (int i = 0; i < 9; i++) step(0, 1, 0, '0);
    chk(empty_n == 1'b0, "R8 empty after replay", empty_n, 0);
    step(0, 0, 1, '0);
    chk(empty_n == 1'b1, "R8 second rewind refills", empty_n, 1);
    step(1, 0, 0, 9'h0C3);
    for (int i = 0; i < 11; i++) step(0, 1, 0, '0);
    chk(dout == 9'h0C3, "R8 write position kept", dout, 9'h0C3);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    t_reset();
    t_order();
    t_both();
    t_half();
    t_retx();
    t_full();
    finish_run();
  end
endmodule